// File: doc/BRIEF.md
# Pushbutton Power Sequencer

This block is a synchronous state machine that decides when an always-on LDO and a buck converter are enabled. It reacts to an active-low pushbutton, a flag that says external power is present, a keep-alive level driven by the application processor, an undervoltage flag and a "LDO near regulation" indication. A parameterised prescaler turns the system clock into a slow tick of about 1.82 ms. Every dwell time and the button hold time are counted in these ticks.

After power-on reset the machine passes through a short power-down state and then parks in a ship-mode state. In ship mode both regulators are off and a low-quiescent flag is raised. A long button press or external power wakes it. During a boot window of fixed length the processor's keep-alive is ignored, so the processor has time to boot. After that window the processor holds the buck on through keep-alive. When keep-alive drops or the supply sags, the buck is shut off for a fixed delay. The machine then waits in an off state, with the LDO still on, for the next wake event. A hard-reset request returns any running state to the initial power-down state.

States: PDN1 (initial power-down), HR (ship mode), PUP1 (first power-up), PON (power-on), PDN2 (power-down), POFF (power-off), PUP2 (re-power-up). Transitions:
- PDN1→HR after the one-second timeout.
- HR→PUP1 on a wake event.
- PUP1→PON after the boot timeout.
- PON→PDN2 when keep-alive is low or the undervoltage flag is set.
- PDN2→POFF after the one-second timeout.
- POFF→PUP2 on a wake event.
- PUP2→PON when keep-alive is high with undervoltage clear, or after the one-second timeout.
- Any state except PDN1 and HR goes to PDN1 on a hard-reset request.

Top module: `pwrseq_fsm`

## Requirements
- R1: While rst_n is low, and after it is released, the machine is in PDN1 with ldo_en, buck_en and ship_mode all 0. After TICKS_1S ticks it moves to HR.
- R2: In HR, ship_mode is 1 and ldo_en and buck_en are 0. ship_mode is 1 in no other state.
- R3: HR moves to PUP1 when ext_pwr is 1, or when btn_n has been held at 0 for TICKS_HOLD consecutive ticks.
- R4: Releasing btn_n (a value of 1) before the hold count completes restarts the count from zero, so a short press causes no transition.
- R5: In PUP1 and PUP2, ldo_en is 1 and buck_en equals ldo_good. buck_en is never 1 while ldo_en is 0.
- R6: PUP1 ignores keep_alive and uvlo, and moves to PON after TICKS_BOOT ticks.
- R7: In PON, ldo_en is 1 and buck_en equals keep_alive AND NOT uvlo. PON moves to PDN2 in the cycle after keep_alive is 0 or uvlo is 1.
- R8: In PDN2, ldo_en is 1 and buck_en is 0 whatever keep_alive is. After TICKS_1S ticks it moves to POFF.
- R9: In POFF, ldo_en is 1 and buck_en is 0. The same wake events as in R3 move it to PUP2.
- R10: PUP2 moves to PON when keep_alive is 1 and uvlo is 0, or after TICKS_1S ticks.
- R11: hard_rst_req at 1 moves PUP1, PON, PDN2, POFF or PUP2 to PDN1 on the next clock. It has no effect in PDN1 or HR.
- R12: Timeouts and the hold count advance only on the prescaler tick, which occurs once every CLKS_PER_TICK clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| btn_n | input | 1 | Pushbutton, 0 = pressed |
| ext_pwr | input | 1 | External supply present |
| keep_alive | input | 1 | Processor request to keep the buck on |
| uvlo | input | 1 | Output undervoltage flag, 1 = low supply |
| ldo_good | input | 1 | LDO is near regulation |
| hard_rst_req | input | 1 | Request to force a return to PDN1 |
| ldo_en | output | 1 | LDO enable |
| buck_en | output | 1 | Buck converter enable |
| ship_mode | output | 1 | Low-quiescent ship-mode flag |

## Verification
The assertions check on every cycle the output pattern of each state and the rule that the buck is never on without the LDO. They also check the PON exit on a lost keep-alive or undervoltage, the forced return on a hard-reset request, and that the initial power-down state never ends between ticks. Only the bench scenarios can show the actual lengths of the dwell and hold windows. They also show that a short press restarts the hold count, and that keep-alive is ignored during the boot window and in PDN2. Finally, they trace the full route from ship mode through both power-up paths and back.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_PDN1 = 3'd0,
        ST_HR   = 3'd1,
        ST_PUP1 = 3'd2,
        ST_PON  = 3'd3,
        ST_PDN2 = 3'd4,
        ST_POFF = 3'd5,
        ST_PUP2 = 3'd6
    } pseq_state_t;

    // States that a hard-reset request is allowed to interrupt
    function automatic logic hrst_applies(pseq_state_t s);
        return (s != ST_PDN1) && (s != ST_HR);
    endfunction

    function automatic int unsigned cnt_width(int unsigned max_val);
        return (max_val > 1) ? $clog2(max_val + 1) : 1;
    endfunction

endpackage

// File: rtl/pwrseq_tick_gen.sv
module pwrseq_tick_gen #(
    parameter int unsigned CLKS_PER_TICK = 91000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_TICK - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = (div_q == LAST);

endmodule

// File: rtl/pwrseq_hold_det.sv
module pwrseq_hold_det
    import pwrseq_pkg::*;
#(
    parameter int unsigned HOLD_TICKS = 220
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_n,
    output logic held
);
    localparam int unsigned HW = cnt_width(HOLD_TICKS);
    localparam logic [HW-1:0] FULL = HW'(HOLD_TICKS);

    logic [HW-1:0] hold_q;

    // Counts ticks while pressed; any release clears the count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (btn_n) begin
            hold_q <= '0;
        end else if (tick && (hold_q != FULL)) begin
            hold_q <= hold_q + 1'b1;
        end
    end

    assign held = (hold_q == FULL) && !btn_n;

endmodule

// File: rtl/pwrseq_dwell_timer.sv
module pwrseq_dwell_timer
    import pwrseq_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = 549,
    parameter int unsigned LONG_TICKS  = 2747
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic use_long,
    output logic expired
);
    localparam int unsigned MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int unsigned CW   = cnt_width(MAXT);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0] SAT        = CW'(MAXT);

    logic [CW-1:0] dwell_q;
    logic [CW-1:0] last_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dwell_q <= '0;
        end else if (restart) begin
            dwell_q <= '0;
        end else if (tick && (dwell_q != SAT)) begin
            dwell_q <= dwell_q + 1'b1;
        end
    end

    assign last_sel = use_long ? LONG_LAST : SHORT_LAST;
    assign expired  = tick && (dwell_q == last_sel);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int unsigned CLKS_PER_TICK = 91000,
    parameter int unsigned TICKS_1S      = 549,
    parameter int unsigned TICKS_HOLD    = 220,
    parameter int unsigned TICKS_BOOT    = 2747
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    input  logic ext_pwr,
    input  logic keep_alive,
    input  logic uvlo,
    input  logic ldo_good,
    input  logic hard_rst_req,
    output logic ldo_en,
    output logic buck_en,
    output logic ship_mode
);
    pseq_state_t state_q;
    pseq_state_t state_d;
    logic        tick;
    logic        held;
    logic        expired;
    logic        wake;

    pwrseq_tick_gen #(
        .CLKS_PER_TICK (CLKS_PER_TICK)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pwrseq_hold_det #(
        .HOLD_TICKS (TICKS_HOLD)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .btn_n (btn_n),
        .held  (held)
    );

    pwrseq_dwell_timer #(
        .SHORT_TICKS (TICKS_1S),
        .LONG_TICKS  (TICKS_BOOT)
    ) u_dwell (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (state_d != state_q),
        .use_long (state_q == ST_PUP1),
        .expired  (expired)
    );

    assign wake = ext_pwr || held;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PDN1;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (hrst_applies(state_q) && hard_rst_req) begin
            state_d = ST_PDN1;
        end else begin
            unique case (state_q)
                ST_PDN1: if (expired) state_d = ST_HR;
                ST_HR:   if (wake) state_d = ST_PUP1;
                ST_PUP1: if (expired) state_d = ST_PON;
                ST_PON:  if (!keep_alive || uvlo) state_d = ST_PDN2;
                ST_PDN2: if (expired) state_d = ST_POFF;
                ST_POFF: if (wake) state_d = ST_PUP2;
                ST_PUP2: if ((keep_alive && !uvlo) || expired) state_d = ST_PON;
                default: state_d = ST_PDN1;
            endcase
        end
    end

    // Output decode
    always_comb begin
        ldo_en    = 1'b0;
        buck_en   = 1'b0;
        ship_mode = 1'b0;
        unique case (state_q)
            ST_PDN1: begin
            end
            ST_HR: begin
                ship_mode = 1'b1;
            end
            ST_PUP1, ST_PUP2: begin
                ldo_en  = 1'b1;
                buck_en = ldo_good;
            end
            ST_PON: begin
                ldo_en  = 1'b1;
                buck_en = keep_alive && !uvlo;
            end
            ST_PDN2, ST_POFF: begin
                ldo_en = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/pwrseq_fsm_chk.sv
module pwrseq_fsm_chk
    import pwrseq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input pseq_state_t state_q,
    input logic        tick,
    input logic        keep_alive,
    input logic        uvlo,
    input logic        hard_rst_req,
    input logic        ldo_en,
    input logic        buck_en,
    input logic        ship_mode
);
    AST_PDN1_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PDN1 |-> !ldo_en && !buck_en && !ship_mode); // R1
    AST_HR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HR |-> !ldo_en && !buck_en && ship_mode); // R2
    AST_SHIP_ONLY_HR: assert property (@(posedge clk) disable iff (!rst_n)
        ship_mode |-> state_q == ST_HR); // R2
    AST_BUCK_NEEDS_LDO: assert property (@(posedge clk) disable iff (!rst_n)
        buck_en |-> ldo_en); // R5
    AST_BOOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PUP1 && !hard_rst_req |=> state_q == ST_PUP1 || state_q == ST_PON); // R6
    AST_PON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PON && (!keep_alive || uvlo) && !hard_rst_req |=> state_q == ST_PDN2); // R7
    AST_PDN2_BUCK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PDN2 |-> ldo_en && !buck_en); // R8
    AST_POFF_BUCK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_POFF |-> ldo_en && !buck_en); // R9
    AST_HRST_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        hard_rst_req && state_q != ST_PDN1 && state_q != ST_HR |=> state_q == ST_PDN1); // R11
    AST_PDN1_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PDN1 && !tick |=> state_q == ST_PDN1); // R12
endmodule

bind pwrseq_fsm pwrseq_fsm_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .tick         (tick),
    .keep_alive   (keep_alive),
    .uvlo         (uvlo),
    .hard_rst_req (hard_rst_req),
    .ldo_en       (ldo_en),
    .buck_en      (buck_en),
    .ship_mode    (ship_mode)
);

// File: tb/pwrseq_fsm_test.sv
module pwrseq_fsm_test;

    localparam int unsigned CPT   = 4;
    localparam int unsigned T1S   = 8;
    localparam int unsigned THOLD = 3;
    localparam int unsigned TBOOT = 20;
    localparam int unsigned NROWS = 25;

    typedef struct packed {
        logic       btn_n;
        logic       ext;
        logic       keep;
        logic       uv;
        logic       good;
        logic       hrst;
        logic [7:0] wait_n;
        logic       e_ldo;
        logic       e_buck;
        logic       e_ship;
        logic [3:0] req;
    } vec_t;

    // btn ext keep uv good hrst wait  ldo buck ship req
    localparam vec_t TBL [NROWS] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd20, 1'b0,1'b0,1'b0, 4'd1},  // R1 still PDN1
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd16, 1'b0,1'b0,1'b1, 4'd1},  // R1 in HR
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd40, 1'b0,1'b0,1'b1, 4'd2},  // R2 HR holds
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'd2,  1'b1,1'b0,1'b0, 4'd3},  // R3 ext wake
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 8'd2,  1'b1,1'b1,1'b0, 4'd5},  // R5 buck follows good
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd60, 1'b1,1'b1,1'b0, 4'd6},  // R6 keep ignored
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd24, 1'b1,1'b1,1'b0, 4'd6},  // R6 now PON
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd2,  1'b1,1'b0,1'b0, 4'd7},  // R7 keep lost
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd20, 1'b1,1'b0,1'b0, 4'd8},  // R8 keep ignored
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd16, 1'b1,1'b0,1'b0, 4'd8},  // R8 to POFF
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 8'd2,  1'b1,1'b1,1'b0, 4'd9},  // R9 ext wake PUP2
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'd2,  1'b1,1'b1,1'b0, 4'd10}, // R10 keep -> PON
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 8'd2,  1'b1,1'b0,1'b0, 4'd7},  // R7 uvlo exit
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd40, 1'b1,1'b0,1'b0, 4'd8},  // R8 POFF
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd20, 1'b1,1'b1,1'b0, 4'd9},  // R9 hold wake PUP2
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd40, 1'b1,1'b0,1'b0, 4'd10}, // R10 timeout
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd40, 1'b1,1'b0,1'b0, 4'd8},  // R8 POFF again
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 8'd2,  1'b0,1'b0,1'b0, 4'd11}, // R11 hrst
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd40, 1'b0,1'b0,1'b1, 4'd1},  // R1 back to HR
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd8,  1'b0,1'b0,1'b1, 4'd4},  // R4 hold partial
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd2,  1'b0,1'b0,1'b1, 4'd4},  // R4 release
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd8,  1'b0,1'b0,1'b1, 4'd4},  // R4 restarted
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'd8,  1'b1,1'b1,1'b0, 4'd3},  // R3 hold wake
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 8'd2,  1'b0,1'b0,1'b0, 4'd11}, // R11 from PUP1
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd40, 1'b0,1'b0,1'b1, 4'd12}  // R12 dwell
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_n = 1'b1;
    logic ext_pwr = 1'b0;
    logic keep_alive = 1'b0;
    logic uvlo = 1'b0;
    logic ldo_good = 1'b0;
    logic hard_rst_req = 1'b0;
    logic ldo_en;
    logic buck_en;
    logic ship_mode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwrseq_fsm #(
        .CLKS_PER_TICK (CPT),
        .TICKS_1S      (T1S),
        .TICKS_HOLD    (THOLD),
        .TICKS_BOOT    (TBOOT)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .btn_n        (btn_n),
        .ext_pwr      (ext_pwr),
        .keep_alive   (keep_alive),
        .uvlo         (uvlo),
        .ldo_good     (ldo_good),
        .hard_rst_req (hard_rst_req),
        .ldo_en       (ldo_en),
        .buck_en      (buck_en),
        .ship_mode    (ship_mode)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(string tag, logic el, logic eb, logic es);
        checks++;
        if (ldo_en !== el || buck_en !== eb || ship_mode !== es) begin
            errors++;
            $display("FAIL %s: ldo/buck/ship actual %b%b%b expected %b%b%b",
                     tag, ldo_en, buck_en, ship_mode, el, eb, es);
        end
    endtask

    initial begin
        wait_n(3);
        check("R1 during reset", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int r = 0; r < NROWS; r++) begin
            btn_n        = TBL[r].btn_n;
            ext_pwr      = TBL[r].ext;
            keep_alive   = TBL[r].keep;
            uvlo         = TBL[r].uv;
            ldo_good     = TBL[r].good;
            hard_rst_req = TBL[r].hrst;
            wait_n(int'(TBL[r].wait_n));
            check($sformatf("row %0d R%0d", r, TBL[r].req),
                  TBL[r].e_ldo, TBL[r].e_buck, TBL[r].e_ship);
        end

        // R11: hard-reset request is ignored in HR
        hard_rst_req = 1'b1;
        wait_n(2);
        check("R11 ignored in HR", 1'b0, 1'b0, 1'b1);
        hard_rst_req = 1'b0;

        // R4: short press in HR does nothing
        btn_n = 1'b0;
        wait_n(6);
        btn_n = 1'b1;
        wait_n(20);
        check("R4 short press", 1'b0, 1'b0, 1'b1);

        // R5: buck follows ldo_good within PUP1, including a drop
        ext_pwr  = 1'b1;
        ldo_good = 1'b1;
        wait_n(3);
        check("R5 buck on with good", 1'b1, 1'b1, 1'b0);
        ldo_good = 1'b0;
        ext_pwr  = 1'b0;
        wait_n(1);
        check("R5 buck off when good drops", 1'b1, 1'b0, 1'b0);

        // R1: reset in mid-run returns to PDN1
        rst_n = 1'b0;
        wait_n(2);
        check("R1 reset mid-run", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        wait_n(20);
        check("R12 PDN1 dwell not short", 1'b0, 1'b0, 1'b0);
        wait_n(16);
        check("R1 PDN1 to HR", 1'b0, 1'b0, 1'b1);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule